// File: doc/BRIEF.md
# Dual-Edge Pixel Input Capture

This block sits at the front of a digital video transmitter. It takes a parallel pixel bus plus data-enable, horizontal sync, vertical sync and three auxiliary control lines. It hands a downstream encoder one 24-bit word per pixel, split into three 8-bit colour channels, plus a flag that marks each word as pixel data or control data. The bus can run in one of two modes. In wide mode, the whole 24-bit pixel arrives on one edge of the pixel clock. In narrow mode, only the low 12 data lines carry the pixel, with one half on each edge of the pixel clock.

The block uses a single clock domain. `clk` runs at twice the pixel rate, and each of its rising edges stands for one edge of the pixel clock. The input `pclk_rise` says whether the current `clk` cycle is a rising-edge slot (1) or a falling-edge slot (0) of the pixel clock. `edge_sel` picks which of the two slots is primary. During blanking, the three channels carry the sync and control bits in fixed positions. In narrow mode, the otherwise unused data lines 23..16 are captured into a configuration byte that stays readable.

Top module: `dep_capture_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, all channel outputs, `is_data_o`, `out_valid_o` and `cfg_o` read zero until the first pixel is presented.
- R2: With `bus_wide`=1, all 24 bits of `pix_in` are taken on the primary slot: blue `ch0_o`=bits 7..0, green `ch1_o`=bits 15..8, red `ch2_o`=bits 23..16.
- R3: With `bus_wide`=0, `pix_in[11:0]` on the primary slot forms pixel bits 11..0. `pix_in[11:0]` on the following secondary slot forms pixel bits 23..12. The pixel is then split into channels as in R2.
- R4: A slot is primary when `pclk_rise` equals `edge_sel`. So `edge_sel`=1 makes the rising pixel-clock edge primary, and `edge_sel`=0 makes the falling edge primary.
- R5: A pixel whose primary slot is at `clk` edge k is presented at edge k+2. `out_valid_o` is high for exactly the one cycle after that edge, and the channel outputs hold until the next presentation.
- R6: When the captured data-enable is 0, the channels carry: `ch0_o`={000000, vsync, hsync}, `ch1_o`={0000000, ctl[0]}, `ch2_o`={000000, ctl[2], ctl[1]}.
- R7: `is_data_o` equals the data-enable value captured with the presented pixel.
- R8: In narrow mode, `pix_in[23:16]` on each primary slot is loaded into `cfg_o`. In wide mode, `cfg_o` holds its value.
- R9: Data lines that carry no pixel bits in the current mode have no effect on the channels: `pix_in[23:12]` in narrow mode, and everything on the secondary slot in wide mode.
- R10: Data-enable, sync and control inputs are sampled on primary slots only. Their values on secondary slots have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pclk_rise | input | 1 | 1: this cycle is a rising pixel-clock slot; 0: a falling slot |
| edge_sel | input | 1 | Primary edge select: 1 rising, 0 falling |
| bus_wide | input | 1 | 1: 24-bit single-edge mode; 0: 12-bit dual-edge mode |
| pix_in | input | 24 | Pixel data bus |
| de_in | input | 1 | Data enable |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| ctl_in | input | 3 | Auxiliary control bits |
| ch0_o | output | 8 | Channel 0: blue or sync bits |
| ch1_o | output | 8 | Channel 1: green or ctl[0] |
| ch2_o | output | 8 | Channel 2: red or ctl[2:1] |
| is_data_o | output | 1 | 1: channels carry pixel data; 0: control |
| out_valid_o | output | 1 | One-cycle strobe for a presented word |
| cfg_o | output | 8 | Configuration byte captured in narrow mode |

## Verification
Pixels with distinct bytes in every lane are sent in wide mode and in narrow mode, under both edge selections. A swapped half, a swapped channel or a wrong primary edge therefore shows up as a different output byte. On every secondary slot the bench drives the inverse of the data, enable, sync and control values. Any sampling on the wrong slot then flips the result, and the same inversion shows that the unused upper lines are ignored. Blanking words use asymmetric sync and control combinations, so that each bit's channel and position is told apart from the others. The configuration byte is compared after narrow pixels and after wide pixels, which shows when it loads and when it holds.

// File: rtl/dep_pkg.sv
package dep_pkg;
   typedef struct packed {
      logic       de;
      logic       hs;
      logic       vs;
      logic [2:0] ctl;
   } sync_t;
endpackage

// File: rtl/dep_slot_capture.sv
module dep_slot_capture
   import dep_pkg::*;
#(
   parameter int HALF_W = 12,
   parameter int CFG_W  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pclk_rise,
   input  logic                  edge_sel,
   input  logic                  bus_wide,
   input  logic [2*HALF_W-1:0]   data,
   input  sync_t                 sync_in,
   output logic                  prim,
   output logic [HALF_W-1:0]     cap_lo,
   output logic [HALF_W-1:0]     cap_up,
   output sync_t                 cap_sync,
   output logic                  primed,
   output logic [CFG_W-1:0]      cfg
);
   localparam int BUS_W = 2 * HALF_W;

   initial begin
      assert (CFG_W <= HALF_W) else $error("CFG_W must fit in the upper half");
   end

   logic cap_wide;

   assign prim = (pclk_rise == edge_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_lo   <= '0;
         cap_up   <= '0;
         cap_sync <= '0;
         cap_wide <= 1'b0;
         primed   <= 1'b0;
         cfg      <= '0;
      end else if (prim) begin
         cap_lo   <= data[HALF_W-1:0];
         cap_sync <= sync_in;
         cap_wide <= bus_wide;
         primed   <= 1'b1;
         if (bus_wide)
            cap_up <= data[BUS_W-1:HALF_W];
         else
            cfg    <= data[BUS_W-1 -: CFG_W];
      end else if (!cap_wide) begin
         cap_up <= data[HALF_W-1:0];
      end
   end

   // R9: in wide mode the secondary slot must not disturb the upper half
   p_up_hold_wide_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!prim && cap_wide) |=> $stable(cap_up));

   // R10: sync sampling happens on primary slots only
   p_sync_primary_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !prim |=> $stable(cap_sync));
endmodule

// File: rtl/dep_chan_map.sv
module dep_chan_map
   import dep_pkg::*;
#(
   parameter int CH_W = 8,
   parameter int N_CH = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        prim,
   input  logic                        primed,
   input  logic [N_CH*CH_W-1:0]        pixel,
   input  sync_t                       cap_sync,
   output logic [N_CH-1:0][CH_W-1:0]   ch,
   output logic                        is_data,
   output logic                        out_valid
);
   initial begin
      assert (CH_W >= 2) else $error("CH_W too small for control bits");
   end

   logic [N_CH-1:0][CH_W-1:0] ctl_word;
   logic [N_CH-1:0][CH_W-1:0] ch_next;

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      if (g == 0) begin : g_sync
         assign ctl_word[g] = CH_W'({cap_sync.vs, cap_sync.hs});
      end else if (g == 1) begin : g_c1
         assign ctl_word[g] = CH_W'(cap_sync.ctl[0]);
      end else if (g == 2) begin : g_c32
         assign ctl_word[g] = CH_W'(cap_sync.ctl[2:1]);
      end else begin : g_none
         assign ctl_word[g] = '0;
      end
      assign ch_next[g] = cap_sync.de ? pixel[g*CH_W +: CH_W] : ctl_word[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ch        <= '0;
         is_data   <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= prim & primed;
         if (prim & primed) begin
            ch      <= ch_next;
            is_data <= cap_sync.de;
         end
      end
   end

   // R5: a presentation strobe follows a primary slot
   p_valid_after_prim_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(prim));

   // R5: outputs hold across secondary slots
   p_hold_secondary_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !prim |=> ($stable(ch) && $stable(is_data)));
endmodule

// File: rtl/dep_capture_top.sv
module dep_capture_top
   import dep_pkg::*;
#(
   parameter int HALF_W = 12,
   parameter int CH_W   = 8,
   parameter int CFG_W  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pclk_rise,
   input  logic                  edge_sel,
   input  logic                  bus_wide,
   input  logic [2*HALF_W-1:0]   pix_in,
   input  logic                  de_in,
   input  logic                  hs_in,
   input  logic                  vs_in,
   input  logic [2:0]            ctl_in,
   output logic [CH_W-1:0]       ch0_o,
   output logic [CH_W-1:0]       ch1_o,
   output logic [CH_W-1:0]       ch2_o,
   output logic                  is_data_o,
   output logic                  out_valid_o,
   output logic [CFG_W-1:0]      cfg_o
);
   localparam int N_CH  = 3;
   localparam int PIX_W = 2 * HALF_W;

   initial begin
      assert (PIX_W == N_CH * CH_W) else $error("pixel width must fill the channels");
   end

   sync_t                       sync_in, cap_sync;
   logic                        prim, primed;
   logic [HALF_W-1:0]           cap_lo, cap_up;
   logic [N_CH-1:0][CH_W-1:0]   ch;

   assign sync_in = '{de: de_in, hs: hs_in, vs: vs_in, ctl: ctl_in};

   dep_slot_capture #(.HALF_W(HALF_W), .CFG_W(CFG_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .pclk_rise(pclk_rise),
      .edge_sel (edge_sel),
      .bus_wide (bus_wide),
      .data     (pix_in),
      .sync_in  (sync_in),
      .prim     (prim),
      .cap_lo   (cap_lo),
      .cap_up   (cap_up),
      .cap_sync (cap_sync),
      .primed   (primed),
      .cfg      (cfg_o)
   );

   dep_chan_map #(.CH_W(CH_W), .N_CH(N_CH)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .prim     (prim),
      .primed   (primed),
      .pixel    ({cap_up, cap_lo}),
      .cap_sync (cap_sync),
      .ch       (ch),
      .is_data  (is_data_o),
      .out_valid(out_valid_o)
   );

   assign ch0_o = ch[0];
   assign ch1_o = ch[1];
   assign ch2_o = ch[2];

   // R8: configuration byte holds while the bus is in wide mode
   p_cfg_hold_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wide |=> $stable(cfg_o));
endmodule

// File: tb/dep_capture_top_bench.sv
module dep_capture_top_bench;
   localparam time PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        pclk_rise = 0, edge_sel = 1, bus_wide = 1;
   logic [23:0] pix_in = '0;
   logic        de_in = 0, hs_in = 0, vs_in = 0;
   logic [2:0]  ctl_in = '0;
   logic [7:0]  ch0_o, ch1_o, ch2_o, cfg_o;
   logic        is_data_o, out_valid_o;

   int errors = 0, checks = 0;
   logic        have_exp = 0;
   logic [7:0]  e0, e1, e2;
   logic        ed;
   string       etag;

   always #(PERIOD/2) clk = ~clk;

   dep_capture_top u_dep_capture_top (
      .clk(clk), .rst_n(rst_n), .pclk_rise(pclk_rise), .edge_sel(edge_sel),
      .bus_wide(bus_wide), .pix_in(pix_in), .de_in(de_in), .hs_in(hs_in),
      .vs_in(vs_in), .ctl_in(ctl_in), .ch0_o(ch0_o), .ch1_o(ch1_o),
      .ch2_o(ch2_o), .is_data_o(is_data_o), .out_valid_o(out_valid_o),
      .cfg_o(cfg_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input bit is_prim, input logic [23:0] d, input logic de,
                       input logic hs, input logic vs, input logic [2:0] ctl);
      @(negedge clk);
      pclk_rise = is_prim ? edge_sel : ~edge_sel;
      pix_in = d; de_in = de; hs_in = hs; vs_in = vs; ctl_in = ctl;
      @(posedge clk);
      #1;
   endtask

   // One pixel: primary slot, check of the previous pixel, secondary slot.
   task automatic px(input string tag, input logic [23:0] p, input logic de,
                     input logic hs, input logic vs, input logic [2:0] ctl,
                     input logic [7:0] cfgb);
      logic [23:0] d1, d2;
      if (bus_wide) begin
         d1 = p;
         d2 = ~p;                              // R9: ignored in wide mode
      end else begin
         d1 = {cfgb, 4'h5, p[11:0]};
         d2 = {12'hA5C, p[23:12]};             // R9: upper lines ignored
      end
      step(1, d1, de, hs, vs, ctl);
      if (have_exp) begin
         check({etag, " R5 valid"}, out_valid_o, 1);
         check({etag, " ch0"}, ch0_o, e0);
         check({etag, " ch1"}, ch1_o, e1);
         check({etag, " ch2"}, ch2_o, e2);
         check({etag, " R7 is_data"}, is_data_o, ed);
      end
      // R10: inverted sync/control on the secondary slot must not matter
      step(0, d2, ~de, ~hs, ~vs, ~ctl);
      check({tag, " R5 strobe low"}, out_valid_o, 0);
      have_exp = 1;
      etag = tag;
      ed = de;
      if (de) begin
         e0 = p[7:0]; e1 = p[15:8]; e2 = p[23:16];
      end else begin
         e0 = {6'b0, vs, hs};
         e1 = {7'b0, ctl[0]};
         e2 = {6'b0, ctl[2], ctl[1]};
      end
   endtask

   task automatic test_reset;
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 ch0", ch0_o, 0);
      check("R1 ch1", ch1_o, 0);
      check("R1 ch2", ch2_o, 0);
      check("R1 valid", out_valid_o, 0);
      check("R1 cfg", cfg_o, 0);
      @(negedge clk);
      rst_n = 1;
      @(posedge clk);
      #1;
      check("R1 after release", {ch0_o, ch1_o, ch2_o, is_data_o, out_valid_o}, 0);
   endtask

   task automatic test_wide(input logic es);
      edge_sel = es;
      bus_wide = 1;
      px(es ? "R2 wide rise A" : "R4 wide fall A", 24'hC3A512, 1, 0, 0, 0, 0);
      px(es ? "R2 wide rise B" : "R4 wide fall B", 24'h1E7F80, 1, 1, 0, 3'b101, 0);
   endtask

   task automatic test_narrow(input logic es);
      edge_sel = es;
      bus_wide = 0;
      px(es ? "R3 narrow rise A" : "R4 narrow fall A", 24'h9B4D26, 1, 0, 1, 0, 8'h3C);
      check("R8 cfg load A", cfg_o, 8'h3C);
      px(es ? "R3 narrow rise B" : "R4 narrow fall B", 24'h06F1E8, 1, 0, 0, 3'b010, 8'hE1);
      check("R8 cfg load B", cfg_o, 8'hE1);
   endtask

   task automatic test_blank;
      edge_sel = 1;
      bus_wide = 1;
      px("R6 blank hs", 24'hFFFFFF, 0, 1, 0, 3'b001, 0);
      px("R6 blank vs", 24'hFFFFFF, 0, 0, 1, 3'b010, 0);
      px("R6 blank ctl3", 24'h123456, 0, 1, 1, 3'b100, 0);
      px("R7 back to data", 24'h5A6B7C, 1, 0, 0, 0, 0);
      check("R8 cfg hold wide", cfg_o, 8'hE1);
   endtask

   initial begin
      test_reset();
      test_wide(1);
      test_narrow(1);
      test_narrow(0);
      test_wide(0);
      test_blank();
      bus_wide = 0;
      edge_sel = 0;
      px("R10 narrow blank", 24'h000000, 0, 1, 0, 3'b110, 8'h77);
      px("R3 flush", 24'hAABBCC, 1, 0, 0, 0, 8'h77);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(PERIOD * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule